// File: doc/BRIEF.md
# Masked Configuration Register Space

This block holds a 256-byte configuration register space for a bus endpoint. Software reaches it through one access port that carries a byte address, an access size of 1, 2 or 4 bytes and, for writes, a 32-bit data word. The port is little-endian: the byte at the access address travels on data bits 7:0.

Every byte has a fixed write mask. A write changes only the bits that its mask allows and leaves all other bits as they were. The masks cover three kinds of bytes:

- The base address windows take their masks from a power-of-two size parameter per window. Software can size a window by writing all ones and reading the value back.
- The low type bits of each window are fixed when the block is built and cannot be written.
- Any write that changes a window byte, or that toggles the I/O or memory decode enable, raises a one-cycle remap pulse. Downstream address decode uses this pulse to rebuild its maps.

Reads are combinational from the register array.

Top module: `cfg_space`

## Requirements
- R1: After reset every byte reads zero, except the fixed type bits of each present window. With the default build, the 32-bit word at 0x14 reads 0x00000001 and the word at 0x18 reads 0x00000008.
- R2: `size_i` selects the access width: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. Multi-byte data is little-endian, with the byte at the access address on bits 7:0.
- R3: A written byte becomes (old & ~mask) | (new & mask). Bytes with a zero mask never change. These include offsets 0x00–0x03, 0x0B, 0x3D and 0x05.
- R4: Offsets 0x0C and 0x3C, and every offset from 0x40 to 0xFF, are fully writable.
- R5: At offset 0x04 only bits 2:0 are writable: I/O enable is bit 0, memory enable is bit 1 and bus master is bit 2. Bits 7:3 stay zero.
- R6: Window n (n = 0..5) is the 32-bit word at 0x10 + 4·n. Its mask is ~(2^L − 1), where L is its size parameter, and L = 0 makes the window read-only zero. With the default build, writing 0xFFFFFFFF gives 0xFFFFF000 at 0x10, 0xFFFFFF01 at 0x14, 0xFFF00008 at 0x18 and 0x00000000 at 0x1C.
- R7: The expansion window is the word at 0x30. It has the same size mask, and bit 0 (its enable) is also writable. With the default build, writing 0xFFFFFFFF reads back 0xFFFF0001.
- R8: Write lanes that would fall past offset 0xFF are dropped and do not wrap around to offset 0x00.
- R9: `remap_o` is high for exactly the one cycle after a clock edge at which a write changed any byte in 0x10–0x27. A write that leaves those bytes unchanged gives no pulse, and so does a write to 0x30 or to 0x40.
- R10: `remap_o` is also high for the cycle after a write that toggles bit 0 or bit 1 of offset 0x04. A change of bit 2 alone gives no pulse.
- R11: A 4-byte read is honoured only at offsets up to 0xFC, and a 2-byte read only at offsets up to 0xFE. Otherwise the read falls back to the next narrower width that fits, down to a single byte, and the unused upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| addr_i | input | 8 | Byte offset of the access |
| size_i | input | 2 | Access width: 0 one byte, 1 two bytes, 2/3 four bytes |
| wdata_i | input | 32 | Write data, little-endian |
| rdata_o | output | 32 | Combinational read data for addr_i/size_i |
| remap_o | output | 1 | One-cycle pulse after a window or decode-enable change |

## Verification
Read data has no register on its path. The bench therefore applies an address and size, waits a fraction of a cycle without a clock edge, and samples `rdata_o`. A write lands in the array at the rising edge where `wr_en_i` is high, and `remap_o` follows from a register updated at that same edge. The bench drives writes on falling edges and samples the pulse at the next falling edge, which falls inside the one cycle the pulse is allowed to last. Every read-back after a write happens at least one edge later, so the stored value has already settled.

// File: rtl/cfg_space_pkg.sv
`timescale 1ns/1ps
package cfg_space_pkg;
  localparam int unsigned CFG_BYTES = 256;
  localparam int unsigned CFG_AW    = $clog2(CFG_BYTES);
  localparam int unsigned HDR_BYTES = 64;
  localparam int unsigned BAR_SLOTS = 7;
  localparam int unsigned ROM_SLOT  = 6;
  localparam int unsigned BAR_BASE  = 'h10;
  localparam int unsigned BAR_SPAN  = 24;
  localparam int unsigned ROM_BASE  = 'h30;
  localparam int unsigned CMD_OFS   = 'h04;
  localparam int unsigned CLS_OFS   = 'h0C;
  localparam int unsigned ILINE_OFS = 'h3C;

  typedef logic [BAR_SLOTS-1:0][4:0] bar_log2_t;
  typedef logic [BAR_SLOTS-1:0][3:0] bar_type_t;
  typedef logic [CFG_BYTES-1:0][7:0] cfg_image_t;

  // window slot owning byte b, BAR_SLOTS when none
  function automatic int unsigned bar_slot(int unsigned b);
    if (b >= BAR_BASE && b < BAR_BASE + BAR_SPAN) return (b - BAR_BASE) / 4;
    if (b >= ROM_BASE && b < ROM_BASE + 4) return ROM_SLOT;
    return BAR_SLOTS;
  endfunction

  function automatic logic [31:0] bar_mask(logic [4:0] lg, logic rom);
    logic [31:0] m;
    m = (lg == 5'd0) ? 32'd0 : ~((32'd1 << lg) - 32'd1);
    if (rom && lg != 5'd0) m[0] = 1'b1;
    return m;
  endfunction

  function automatic cfg_image_t mask_image(bar_log2_t lg);
    cfg_image_t img;
    for (int unsigned b = 0; b < CFG_BYTES; b++) begin
      int unsigned s;
      logic [2:0]  si;
      logic [31:0] w;
      s  = bar_slot(b);
      si = 3'(s);
      w  = '0;
      if (s < BAR_SLOTS) w = bar_mask(lg[si], s == ROM_SLOT) >> (8 * (b % 4));
      if (b >= HDR_BYTES || b == CLS_OFS || b == ILINE_OFS) w = 32'hFF;
      if (b == CMD_OFS) w = 32'h07;
      img[b[CFG_AW-1:0]] = w[7:0];
    end
    return img;
  endfunction

  function automatic cfg_image_t rst_image(bar_log2_t lg, bar_type_t ty);
    cfg_image_t img;
    for (int unsigned b = 0; b < CFG_BYTES; b++) begin
      int unsigned s;
      logic [2:0]  si;
      logic [31:0] w;
      s  = bar_slot(b);
      si = 3'(s);
      w  = '0;
      if (s < BAR_SLOTS && lg[si] != 5'd0)
        w = ({28'd0, ty[si]} & ~bar_mask(lg[si], s == ROM_SLOT)) >> (8 * (b % 4));
      img[b[CFG_AW-1:0]] = w[7:0];
    end
    return img;
  endfunction
endpackage

// File: rtl/cfg_wr_lanes.sv
`timescale 1ns/1ps
module cfg_wr_lanes #(
  parameter int unsigned N  = 256,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic                wr_en_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [1:0]          size_i,
  input  logic [31:0]         data_i,
  output logic [N-1:0]        we_o,
  output logic [N-1:0][7:0]   wd_o
);
  logic [2:0] nbytes;

  always_comb begin
    unique case (size_i)
      2'd0:    nbytes = 3'd1;
      2'd1:    nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
  end

  // lanes past N-1 never match: no wrap to offset 0
  for (genvar b = 0; b < N; b++) begin : g_lane
    logic [AW:0] off;
    logic        hit;
    assign off      = (AW+1)'(b) - {1'b0, addr_i};
    assign hit      = ({1'b0, addr_i} <= (AW+1)'(b)) && (off < {{(AW-2){1'b0}}, nbytes});
    assign we_o[b]  = wr_en_i && hit;
    assign wd_o[b]  = 8'(data_i >> {off[1:0], 3'b000});
  end
endmodule

// File: rtl/cfg_rd_mux.sv
`timescale 1ns/1ps
module cfg_rd_mux #(
  parameter int unsigned N  = 256,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic [N-1:0][7:0] cfg_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [1:0]        size_i,
  output logic [31:0]       data_o
);
  logic [7:0] b0, b1, b2, b3;
  logic [AW:0] a_ext;

  assign a_ext = {1'b0, addr_i};
  assign b0 = cfg_i[addr_i];
  assign b1 = cfg_i[AW'(addr_i + AW'(1))];
  assign b2 = cfg_i[AW'(addr_i + AW'(2))];
  assign b3 = cfg_i[AW'(addr_i + AW'(3))];

  // narrow the access when it would run past the top byte
  always_comb begin
    data_o = {24'd0, b0};
    if (size_i != 2'd0 && a_ext <= (AW+1)'(N - 2)) data_o = {16'd0, b1, b0};
    if (size_i[1] && a_ext <= (AW+1)'(N - 4))      data_o = {b3, b2, b1, b0};
  end
endmodule

// File: rtl/cfg_space.sv
`timescale 1ns/1ps
module cfg_space
  import cfg_space_pkg::*;
#(
  parameter bar_log2_t BAR_LOG2 = {5'd16, 5'd0, 5'd0, 5'd0, 5'd20, 5'd8, 5'd12},
  parameter bar_type_t BAR_TYPE = {4'h0,  4'h0, 4'h0, 4'h0, 4'h8,  4'h1, 4'h0}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              remap_o
);
  localparam cfg_image_t  WMASK   = mask_image(BAR_LOG2);
  localparam cfg_image_t  RST_IMG = rst_image(BAR_LOG2, BAR_TYPE);
  localparam int unsigned BAR_TOP = BAR_BASE + BAR_SPAN - 1;

  cfg_image_t           cfg_q, cfg_d, lane_wd;
  logic [CFG_BYTES-1:0] lane_we;
  logic                 bar_chg, cmd_chg, remap_q;

  cfg_wr_lanes #(.N(CFG_BYTES), .AW(CFG_AW)) u_lanes (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .size_i  (size_i),
    .data_i  (wdata_i),
    .we_o    (lane_we),
    .wd_o    (lane_wd)
  );

  for (genvar b = 0; b < CFG_BYTES; b++) begin : g_merge
    assign cfg_d[b] = lane_we[b] ? ((cfg_q[b] & ~WMASK[b]) | (lane_wd[b] & WMASK[b]))
                                 : cfg_q[b];
  end

  assign bar_chg = cfg_d[BAR_TOP:BAR_BASE] != cfg_q[BAR_TOP:BAR_BASE];
  assign cmd_chg = cfg_d[CMD_OFS][1:0] != cfg_q[CMD_OFS][1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= RST_IMG;
      remap_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      remap_q <= bar_chg | cmd_chg;
    end
  end

  assign remap_o = remap_q;

  cfg_rd_mux #(.N(CFG_BYTES), .AW(CFG_AW)) u_rd (
    .cfg_i  (cfg_q),
    .addr_i (addr_i),
    .size_i (size_i),
    .data_o (rdata_o)
  );
endmodule

// File: rtl/cfg_space_chk.sv
`timescale 1ns/1ps
module cfg_space_chk
  import cfg_space_pkg::*;
#(
  parameter bar_log2_t BAR_LOG2 = '0,
  parameter bar_type_t BAR_TYPE = '0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       remap_o,
  input cfg_image_t cfg_q
);
  localparam int unsigned BAR_TOP = BAR_BASE + BAR_SPAN - 1;

  p_remap_needs_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_o |-> $past(wr_en_i));

  p_bar_change_remap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[BAR_TOP:BAR_BASE] != $past(cfg_q[BAR_TOP:BAR_BASE])) |-> remap_o);

  p_cmd_toggle_remap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[CMD_OFS][1:0] != $past(cfg_q[CMD_OFS][1:0])) |-> remap_o);

  p_cmd_high_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[CMD_OFS][7:3] == 5'd0);

  p_id_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cfg_q[3:0]));

  for (genvar s = 0; s < BAR_SLOTS; s++) begin : g_bar
    localparam int unsigned BASE = (s == ROM_SLOT) ? ROM_BASE : BAR_BASE + 4 * s;
    localparam logic [31:0] M    = bar_mask(BAR_LOG2[s], s == ROM_SLOT);
    localparam logic [31:0] TY   = (BAR_LOG2[s] == 5'd0) ? 32'd0 : ({28'd0, BAR_TYPE[s]} & ~M);
    logic [31:0] word;
    assign word = {cfg_q[BASE+3], cfg_q[BASE+2], cfg_q[BASE+1], cfg_q[BASE]};
    p_bar_fixed_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (word & ~M) == TY);
  end
endmodule

bind cfg_space cfg_space_chk #(.BAR_LOG2(BAR_LOG2), .BAR_TYPE(BAR_TYPE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .remap_o (remap_o),
  .cfg_q   (cfg_q)
);

// File: tb/cfg_space_test.sv
`timescale 1ns/1ps
module cfg_space_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        remap;
  int          checks = 0;
  int          errors = 0;
  logic        last_remap;

  always #2.5 clk = ~clk;

  cfg_space uut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .size_i  (size),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .remap_o (remap)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %08h expected %08h", req, got, exp);
    end
  endtask

  // write at one edge; last_remap holds remap_o sampled in the following cycle
  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    addr = a; size = sz; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    last_remap = remap;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    addr = a; size = sz;
    #1;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R9 remap low after reset", {31'd0, remap}, 32'd0);
    rd(8'h10, 2'd2, v); chk("R1 window0 reset", v, 32'h0);
    rd(8'h14, 2'd2, v); chk("R1 window1 type bits", v, 32'h1);
    rd(8'h18, 2'd2, v); chk("R1 window2 type bits", v, 32'h8);
    rd(8'h30, 2'd2, v); chk("R1 expansion reset", v, 32'h0);
    rd(8'h40, 2'd2, v); chk("R1 user area reset", v, 32'h0);
  endtask

  task automatic t_wide;
    logic [31:0] v;
    wr(8'h40, 2'd2, 32'h11223344);
    chk("R9 no remap on user write", {31'd0, last_remap}, 32'd0);
    rd(8'h40, 2'd0, v); chk("R2 byte lane 0", v, 32'h44);
    rd(8'h42, 2'd1, v); chk("R2 half little-endian", v, 32'h1122);
    rd(8'h40, 2'd3, v); chk("R4 word user area", v, 32'h11223344);
    wr(8'h0B, 2'd1, 32'h00005AA5);
    rd(8'h0C, 2'd0, v); chk("R4 cache line byte", v, 32'h5A);
    rd(8'h0B, 2'd0, v); chk("R3 class byte read-only", v, 32'h0);
    wr(8'h3C, 2'd1, 32'h0000FF77);
    rd(8'h3C, 2'd1, v); chk("R4 irq line writable, pin read-only R3", v, 32'h0077);
  endtask

  task automatic t_ro;
    logic [31:0] v;
    wr(8'h00, 2'd2, 32'hFFFFFFFF);
    rd(8'h00, 2'd2, v); chk("R3 id word read-only", v, 32'h0);
  endtask

  task automatic t_cmd;
    logic [31:0] v;
    wr(8'h04, 2'd1, 32'h0000FFFF);
    chk("R10 remap on enable toggle", {31'd0, last_remap}, 32'd1);
    rd(8'h04, 2'd1, v); chk("R5 command mask", v, 32'h0007);
    wr(8'h04, 2'd0, 32'h03);
    chk("R10 no remap on bus master only", {31'd0, last_remap}, 32'd0);
    rd(8'h04, 2'd0, v); chk("R5 bus master cleared", v, 32'h03);
    wr(8'h04, 2'd0, 32'h01);
    chk("R10 remap on memory enable clear", {31'd0, last_remap}, 32'd1);
  endtask

  task automatic t_bar;
    logic [31:0] v;
    wr(8'h10, 2'd2, 32'hFFFFFFFF);
    chk("R9 remap on window change", {31'd0, last_remap}, 32'd1);
    @(negedge clk);
    chk("R9 pulse lasts one cycle", {31'd0, remap}, 32'd0);
    rd(8'h10, 2'd2, v); chk("R6 window0 sizing", v, 32'hFFFFF000);
    wr(8'h10, 2'd2, 32'hFFFFFFFF);
    chk("R9 no remap on unchanged write", {31'd0, last_remap}, 32'd0);
    wr(8'h14, 2'd2, 32'hFFFFFFFF);
    rd(8'h14, 2'd2, v); chk("R6 window1 sizing", v, 32'hFFFFFF01);
    wr(8'h18, 2'd2, 32'hFFFFFFFF);
    rd(8'h18, 2'd2, v); chk("R6 window2 sizing", v, 32'hFFF00008);
    wr(8'h1C, 2'd2, 32'hFFFFFFFF);
    chk("R9 no remap absent window", {31'd0, last_remap}, 32'd0);
    rd(8'h1C, 2'd2, v); chk("R6 absent window zero", v, 32'h0);
    wr(8'h11, 2'd0, 32'h00);
    chk("R9 remap on byte change", {31'd0, last_remap}, 32'd1);
    rd(8'h10, 2'd2, v); chk("R3 byte merge in window0", v, 32'hFFFF0000);
  endtask

  task automatic t_rom;
    logic [31:0] v;
    wr(8'h30, 2'd2, 32'hFFFFFFFF);
    chk("R9 no remap for expansion", {31'd0, last_remap}, 32'd0);
    rd(8'h30, 2'd2, v); chk("R7 expansion sizing", v, 32'hFFFF0001);
    wr(8'h30, 2'd0, 32'h00);
    rd(8'h30, 2'd2, v); chk("R7 enable bit cleared", v, 32'hFFFF0000);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(8'hFE, 2'd2, 32'hAABBCCDD);
    rd(8'hFE, 2'd0, v); chk("R8 lane 0xFE", v, 32'hDD);
    rd(8'hFF, 2'd0, v); chk("R8 lane 0xFF", v, 32'hCC);
    rd(8'h00, 2'd2, v); chk("R8 no wrap", v, 32'h0);
    rd(8'hFE, 2'd2, v); chk("R11 word at 0xFE narrows", v, 32'h0000CCDD);
    rd(8'hFC, 2'd2, v); chk("R11 word at 0xFC honoured", v, 32'hCCDD0000);
    rd(8'hFD, 2'd2, v); chk("R11 word at 0xFD narrows to half", v, 32'h0000DD00);
    rd(8'hFF, 2'd1, v); chk("R11 half at 0xFF narrows", v, 32'h000000CC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_wide();
    t_ro();
    t_cmd();
    t_bar();
    t_rom();
    t_edge();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule